// File: doc/BRIEF.md
# CAN bit timing unit

This block turns a module clock into CAN bit timing. A clock-source select picks one of two module-clock enable streams: a crystal-oscillator enable or an enable running at twice the system clock rate. A programmable prescaler divides the selected stream into time-quantum ticks. A state machine then counts quanta through three states. `SEG_SYNC` is the sync segment. `SEG_PH1` is time segment 1, which covers propagation plus phase segment 1. `SEG_PH2` is time segment 2. The block pulses a sample-point strobe when time segment 1 ends and a bit-boundary strobe when time segment 2 ends. The bit rate is therefore the quantum rate divided by (1 + TSEG1 + TSEG2).

The received line first passes through a two-flop synchronizer. It is then checked for recessive-to-dominant edges, and only on quantum ticks. While the bus is idle, such an edge causes a hard synchronization: the quantum in which the edge is seen becomes the sync segment, and the bit carries on in `SEG_PH1`. At other times the edge causes a resynchronization. An edge seen in `SEG_PH1` lengthens that segment, and an edge seen in `SEG_PH2` shortens that segment. Each correction is capped at the programmed jump width, and at most one resynchronization is made per bit.

State transitions on a quantum tick:
- `SEG_SYNC` to `SEG_PH1`.
- `SEG_PH1` to `SEG_PH2` when the last quantum of the segment, including any extension, ends. This transition raises the sample strobe.
- `SEG_PH2` to `SEG_SYNC` when the last quantum of the segment, after any shortening, ends. This transition raises the bit-end strobe.
- Any state to `SEG_PH1` on a hard synchronization.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts (presc_i + 1) enabled module-clock cycles, where presc_i is a 6-bit field holding the value minus one (1 to 64). The state machine advances only on quantum ticks.
- R2: When src_sel_i is 0, osc_en_i is the module-clock enable. When src_sel_i is 1, dbl_en_i is the module-clock enable.
- R3: A bit is one sync quantum, then (tseg1_i + 1) quanta of time segment 1, then (tseg2_i + 1) quanta of time segment 2. tseg1_i is a 4-bit value-minus-one field with legal values 3 to 15. tseg2_i is a 3-bit value-minus-one field with legal values 1 to 7. sample_o pulses at the end of the last quantum of segment 1. bit_end_o pulses at the end of the last quantum of segment 2.
- R4: sample_o and bit_end_o are each high for exactly one clock per event.
- R5: While rst_ni is low, sample_o, bit_end_o and tq_tick_o are 0 and seg_o reads 0. The seg_o codes are 0 for sync, 1 for segment 1 and 2 for segment 2.
- R6: When bus_idle_i is 1, a falling edge of rx_i (1 is recessive, 0 is dominant) seen in any quantum makes that quantum the sync segment. The next quantum is the first quantum of segment 1, and no correction limit applies.
- R7: When the bus is not idle, a falling edge seen in quantum k (counting from 0) of segment 1 lengthens that segment by min(k + 1, sjw_i + 1) quanta. sjw_i is a 2-bit value-minus-one field (1 to 4).
- R8: When the bus is not idle, a falling edge seen in segment 2 with r quanta of the segment still to follow shortens the segment by min(r, sjw_i + 1). If r is at most sjw_i + 1, the bit ends with the quantum in which the edge was seen.
- R9: A falling edge seen in the sync quantum causes no correction.
- R10: Once a bit has been corrected by a resynchronization, further falling edges in that bit cause no correction.
- R11: The receive input is synchronized through two flops before edge detection. Rising edges cause no correction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| osc_en_i | input | 1 | Module-clock enable from the oscillator |
| dbl_en_i | input | 1 | Module-clock enable at twice the system rate |
| src_sel_i | input | 1 | Module-clock source select (0 oscillator, 1 double-rate) |
| presc_i | input | 6 | Prescaler divide value minus one |
| tseg1_i | input | 4 | Time segment 1 length minus one |
| tseg2_i | input | 3 | Time segment 2 length minus one |
| sjw_i | input | 2 | Jump width minus one |
| rx_i | input | 1 | Received bus level (1 recessive) |
| bus_idle_i | input | 1 | Bus idle flag, selects hard synchronization |
| tq_tick_o | output | 1 | One-clock pulse per time quantum |
| sample_o | output | 1 | Sample-point strobe |
| bit_end_o | output | 1 | Bit-boundary strobe |
| seg_o | output | 2 | Current segment code |

## Verification
The assertions assume that the timing fields and the jump width stay constant outside reset. They also assume the fields hold legal values, because the caps on stored corrections are checked against the live jump-width input. The bench therefore loads each configuration while reset is held and keeps it fixed for the rest of that scenario. Every receive transition is placed relative to an observed strobe, with the line held for several quanta, so each edge lands in a known quantum after the two synchronizer stages.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_PH1  = 2'd1,
        SEG_PH2  = 2'd2
    } seg_e;

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
    parameter int PRESC_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               osc_en_i,
    input  logic               dbl_en_i,
    input  logic               src_sel_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tq_tick_o
);

    logic               mclk_en;
    logic [PRESC_W-1:0] div_cnt_q;
    logic               tick_q;

    // Source select works on enables, so the block stays in one clock domain.
    assign mclk_en = src_sel_i ? dbl_en_i : osc_en_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_cnt_q <= '0;
            tick_q    <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (mclk_en) begin
                if (div_cnt_q >= presc_i) begin
                    div_cnt_q <= '0;
                    tick_q    <= 1'b1;
                end else begin
                    div_cnt_q <= div_cnt_q + 1'b1;
                end
            end
        end
    end

    assign tq_tick_o = tick_q;

    p_tick_follows_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_q |-> $past(mclk_en));

    p_tick_isolated_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_q && presc_i != '0) |=> !tick_q);

endmodule

// File: rtl/can_bt_rx_edge.sv
module can_bt_rx_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_i,
    input  logic tq_tick_i,
    output logic fall_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    logic                   last_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
        end
    end

    assign rx_s = sync_q[SYNC_STAGES-1];

    // The level is compared only from one quantum to the next.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            last_q <= 1'b1;
        end else if (tq_tick_i) begin
            last_q <= rx_s;
        end
    end

    assign fall_o = tq_tick_i && last_q && !rx_s;

    p_fall_sees_old_dominant_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> ($past(rx_i, SYNC_STAGES) == 1'b0));

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
    import can_bt_pkg::*;
#(
    parameter int TSEG1_W = 4,
    parameter int TSEG2_W = 3,
    parameter int SJW_W   = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               tq_tick_i,
    input  logic               fall_i,
    input  logic               bus_idle_i,
    input  logic [TSEG1_W-1:0] tseg1_i,
    input  logic [TSEG2_W-1:0] tseg2_i,
    input  logic [SJW_W-1:0]   sjw_i,
    output logic               sample_o,
    output logic               bit_end_o,
    output seg_e               seg_o
);

    localparam int WIDE_W = (TSEG1_W > SJW_W) ? TSEG1_W : SJW_W;
    localparam int LW     = WIDE_W + 2;

    seg_e          state_q, state_d;
    logic [LW-1:0] qcnt_q, qcnt_d;
    logic [LW-1:0] ext_q, ext_d;
    logic [LW-1:0] shr_q, shr_d;
    logic          done_q, done_d;

    logic [LW-1:0] q_inc, jump_max, adj1, ext_use, len1;
    logic [LW-1:0] base2, err2, adj2, shr_use, len2;
    logic          fin1, fin2, hard_sync, resync_ok;

    // Segment lengths, including a correction made in this very quantum.
    always_comb begin
        q_inc     = qcnt_q + LW'(1);
        jump_max  = LW'(sjw_i) + LW'(1);
        resync_ok = fall_i && !done_q;
        hard_sync = tq_tick_i && fall_i && bus_idle_i;

        adj1    = (q_inc < jump_max) ? q_inc : jump_max;
        ext_use = resync_ok ? adj1 : ext_q;
        len1    = LW'(tseg1_i) + LW'(1) + ext_use;
        fin1    = q_inc >= len1;

        base2   = LW'(tseg2_i) + LW'(1);
        err2    = (q_inc >= base2) ? '0 : base2 - q_inc;
        adj2    = (err2 < jump_max) ? err2 : jump_max;
        shr_use = resync_ok ? adj2 : shr_q;
        len2    = base2 - shr_use;
        fin2    = q_inc >= len2;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        qcnt_d  = qcnt_q;
        ext_d   = ext_q;
        shr_d   = shr_q;
        done_d  = done_q;
        if (tq_tick_i) begin
            if (hard_sync) begin
                state_d = SEG_PH1;
                qcnt_d  = '0;
                ext_d   = '0;
                shr_d   = '0;
                done_d  = 1'b0;
            end else begin
                unique case (state_q)
                    SEG_SYNC: begin
                        state_d = SEG_PH1;
                        qcnt_d  = '0;
                    end
                    SEG_PH1: begin
                        if (resync_ok) begin
                            done_d = 1'b1;
                            ext_d  = ext_use;
                        end
                        if (fin1) begin
                            state_d = SEG_PH2;
                            qcnt_d  = '0;
                        end else begin
                            qcnt_d = q_inc;
                        end
                    end
                    SEG_PH2: begin
                        if (resync_ok) begin
                            done_d = 1'b1;
                            shr_d  = shr_use;
                        end
                        if (fin2) begin
                            state_d = SEG_SYNC;
                            qcnt_d  = '0;
                            ext_d   = '0;
                            shr_d   = '0;
                            done_d  = 1'b0;
                        end else begin
                            qcnt_d = q_inc;
                        end
                    end
                    default: begin
                        state_d = SEG_SYNC;
                        qcnt_d  = '0;
                    end
                endcase
            end
        end
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SEG_SYNC;
            qcnt_q  <= '0;
            ext_q   <= '0;
            shr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            qcnt_q  <= qcnt_d;
            ext_q   <= ext_d;
            shr_q   <= shr_d;
            done_q  <= done_d;
        end
    end

    // Outputs.
    always_comb begin
        seg_o     = state_q;
        sample_o  = tq_tick_i && !hard_sync && (state_q == SEG_PH1) && fin1;
        bit_end_o = tq_tick_i && !hard_sync && (state_q == SEG_PH2) && fin2;
    end

    p_sample_enters_ph2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> (seg_o == SEG_PH2));

    p_end_enters_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_end_o |=> (seg_o == SEG_SYNC));

    p_sample_one_clock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_o |=> !sample_o);

    p_end_one_clock_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_end_o |=> !bit_end_o);

    p_hold_between_ticks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tq_tick_i |=> ($stable(seg_o) && $stable(qcnt_q)));

    p_hard_sync_restart_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tq_tick_i && fall_i && bus_idle_i) |=> (seg_o == SEG_PH1 && qcnt_q == '0));

    p_ext_capped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_q <= (LW'(sjw_i) + LW'(1)));

    p_shr_capped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shr_q <= (LW'(sjw_i) + LW'(1)));

    p_flag_cleared_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_end_o |=> !done_q);

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bt_pkg::*;
#(
    parameter int PRESC_W     = 6,
    parameter int TSEG1_W     = 4,
    parameter int TSEG2_W     = 3,
    parameter int SJW_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               osc_en_i,
    input  logic               dbl_en_i,
    input  logic               src_sel_i,
    input  logic [PRESC_W-1:0] presc_i,
    input  logic [TSEG1_W-1:0] tseg1_i,
    input  logic [TSEG2_W-1:0] tseg2_i,
    input  logic [SJW_W-1:0]   sjw_i,
    input  logic               rx_i,
    input  logic               bus_idle_i,
    output logic               tq_tick_o,
    output logic               sample_o,
    output logic               bit_end_o,
    output logic [1:0]         seg_o
);

    logic tq_tick;
    logic fall;
    seg_e seg;

    can_bt_prescaler #(
        .PRESC_W (PRESC_W)
    ) u_presc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .osc_en_i  (osc_en_i),
        .dbl_en_i  (dbl_en_i),
        .src_sel_i (src_sel_i),
        .presc_i   (presc_i),
        .tq_tick_o (tq_tick)
    );

    can_bt_rx_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_rx (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rx_i      (rx_i),
        .tq_tick_i (tq_tick),
        .fall_o    (fall)
    );

    can_bt_seq #(
        .TSEG1_W (TSEG1_W),
        .TSEG2_W (TSEG2_W),
        .SJW_W   (SJW_W)
    ) u_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tq_tick_i  (tq_tick),
        .fall_i     (fall),
        .bus_idle_i (bus_idle_i),
        .tseg1_i    (tseg1_i),
        .tseg2_i    (tseg2_i),
        .sjw_i      (sjw_i),
        .sample_o   (sample_o),
        .bit_end_o  (bit_end_o),
        .seg_o      (seg)
    );

    assign tq_tick_o = tq_tick;
    assign seg_o     = seg;

    p_strobes_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sample_o && bit_end_o));

endmodule

// File: tb/can_bit_timer_tb_top.sv
`timescale 1ns/1ps
module can_bit_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b1;
    logic       dbl_en = 1'b0;
    logic       src_sel = 1'b0;
    logic [5:0] presc = '0;
    logic [3:0] tseg1 = 4'd5;
    logic [2:0] tseg2 = 3'd7;
    logic [1:0] sjw = 2'd1;
    logic       rx = 1'b1;
    logic       bus_idle = 1'b0;
    logic       tq_tick, sample, bit_end;
    logic [1:0] seg;

    always #4 clk = ~clk;

    always @(negedge clk) dbl_en <= ~dbl_en;

    can_bit_timer dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .osc_en_i   (osc_en),
        .dbl_en_i   (dbl_en),
        .src_sel_i  (src_sel),
        .presc_i    (presc),
        .tseg1_i    (tseg1),
        .tseg2_i    (tseg2),
        .sjw_i      (sjw),
        .rx_i       (rx),
        .bus_idle_i (bus_idle),
        .tq_tick_o  (tq_tick),
        .sample_o   (sample),
        .bit_end_o  (bit_end),
        .seg_o      (seg)
    );

    typedef struct {
        bit    is_end;
        int    delta;
        string req;
    } exp_t;

    exp_t sb_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    int   cyc = 0;
    int   last_ev = 0;
    bit   first_ev = 1'b1;
    bit   prev_s = 1'b0;
    bit   prev_e = 1'b0;

    task automatic check(input bit ok, input string r, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic push(input bit is_end, input int d, input string r);
        exp_t it;
        it.is_end = is_end;
        it.delta  = d;
        it.req    = r;
        sb_q.push_back(it);
    endtask

    // Monitor: compares strobe kind and spacing with the scoreboard.
    always @(negedge clk) begin
        exp_t it;
        cyc = cyc + 1;
        if (!rst_n) begin
            first_ev = 1'b1;
            last_ev  = cyc;
            prev_s   = 1'b0;
            prev_e   = 1'b0;
        end else begin
            if (sample || bit_end) begin
                check(!((sample && prev_s) || (bit_end && prev_e)), "R4",
                      "strobe width", 2, 1);
                if (first_ev) begin
                    first_ev = 1'b0;
                end else if (sb_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected strobe", cyc - last_ev, 0);
                end else begin
                    it = sb_q.pop_front();
                    check(it.is_end == bit_end, it.req, "strobe kind",
                          int'(bit_end), int'(it.is_end));
                    check((cyc - last_ev) == it.delta, it.req, "interval",
                          cyc - last_ev, it.delta);
                end
                last_ev = cyc;
            end
            prev_s = sample;
            prev_e = bit_end;
        end
    end

    task automatic start(input int p, input int t1, input int t2, input int j,
                         input bit sel, input bit idle);
        @(negedge clk);
        rst_n    = 1'b0;
        presc    = 6'(p);
        tseg1    = 4'(t1);
        tseg2    = 3'(t2);
        sjw      = 2'(j);
        src_sel  = sel;
        bus_idle = idle;
        rx       = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_scn();
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
    endtask

    task automatic wait_sample();
        do @(negedge clk); while (sample !== 1'b1);
    endtask

    task automatic wait_end();
        do @(negedge clk); while (bit_end !== 1'b1);
    endtask

    task automatic normal_bits(input int n, input int q, input int t1, input int t2,
                               input string r);
        for (int i = 0; i < n; i++) begin
            push(1'b1, (t2 + 1) * q, r);
            push(1'b0, (t1 + 2) * q, r);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R5: outputs under reset
        repeat (3) @(negedge clk);
        check(sample == 1'b0, "R5", "sample in reset", int'(sample), 0);
        check(bit_end == 1'b0, "R5", "bit_end in reset", int'(bit_end), 0);
        check(tq_tick == 1'b0, "R5", "tick in reset", int'(tq_tick), 0);
        check(seg == 2'd0, "R5", "segment in reset", int'(seg), 0);

        // R3 basic bit structure, one cycle per quantum
        start(0, 5, 7, 1, 1'b0, 1'b0);
        normal_bits(3, 1, 5, 7, "R3");
        finish_scn();

        // R1 prescale by three, oscillator source (R2)
        start(2, 3, 1, 1, 1'b0, 1'b0);
        normal_bits(2, 3, 3, 1, "R1");
        finish_scn();

        // R2 double-rate source enabled on every other clock
        start(2, 3, 1, 1, 1'b1, 1'b0);
        normal_bits(2, 6, 3, 1, "R2");
        finish_scn();

        // R1 R3 largest fields
        start(63, 15, 7, 3, 1'b0, 1'b0);
        normal_bits(1, 64, 15, 7, "R1");
        finish_scn();

        // R3 smallest legal segments
        start(0, 3, 1, 0, 1'b0, 1'b0);
        normal_bits(3, 1, 3, 1, "R3");
        finish_scn();

        // R8 shortening, R11 rising edge without effect
        start(0, 5, 7, 1, 1'b0, 1'b0);
        push(1'b1, 8, "R3");
        push(1'b0, 7, "R3");
        push(1'b1, 6, "R8");
        push(1'b0, 7, "R11");
        push(1'b1, 7, "R8");
        push(1'b0, 7, "R11");
        push(1'b1, 8, "R11");
        wait_sample();
        wait_sample();
        rx = 1'b0;
        wait_end();
        rx = 1'b1;
        wait_sample();
        repeat (5) @(negedge clk);
        rx = 1'b0;
        wait_end();
        rx = 1'b1;
        finish_scn();

        // R7 lengthening, R10 single resync, R9 edge in sync
        start(0, 5, 7, 1, 1'b0, 1'b0);
        push(1'b1, 8, "R3");
        push(1'b0, 8, "R7");
        push(1'b1, 8, "R10");
        push(1'b0, 7, "R10");
        push(1'b1, 8, "R3");
        push(1'b0, 9, "R7");
        push(1'b1, 8, "R7");
        push(1'b0, 7, "R9");
        push(1'b1, 8, "R9");
        wait_sample();
        wait_end();
        rx = 1'b0;
        repeat (3) @(negedge clk);
        rx = 1'b1;
        wait_sample();
        rx = 1'b0;
        wait_end();
        rx = 1'b1;
        wait_sample();
        wait_end();
        repeat (3) @(negedge clk);
        rx = 1'b0;
        wait_sample();
        rx = 1'b1;
        repeat (7) @(negedge clk);
        rx = 1'b0;
        wait_end();
        wait_sample();
        wait_end();
        rx = 1'b1;
        finish_scn();

        // R6 hard synchronization while idle
        start(0, 5, 7, 1, 1'b0, 1'b1);
        push(1'b0, 10, "R6");
        push(1'b1, 8, "R6");
        push(1'b0, 11, "R6");
        push(1'b1, 8, "R6");
        wait_sample();
        repeat (2) @(negedge clk);
        rx = 1'b0;
        repeat (3) @(negedge clk);
        rx = 1'b1;
        wait_end();
        repeat (3) @(negedge clk);
        rx = 1'b0;
        wait_sample();
        rx = 1'b1;
        finish_scn();

        // R7 largest jump width caps the extension at four
        start(0, 5, 7, 3, 1'b0, 1'b0);
        push(1'b1, 8, "R3");
        push(1'b0, 11, "R7");
        push(1'b1, 8, "R7");
        wait_sample();
        wait_end();
        repeat (5) @(negedge clk);
        rx = 1'b0;
        wait_sample();
        rx = 1'b1;
        finish_scn();

        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule